// File: doc/BRIEF.md
# Frame-Count Timestamp Capture Unit

This block counts single-cycle frame strobes against a programmable 16-bit limit held in a software-writable register. When the running count reaches the limit, the block copies the present value of its own free-running 32-bit cycle timer into a read-only snapshot register and raises a sticky interrupt level. Software uses the snapshot to measure the real time taken by a known number of frames, for example to estimate the drift between a frame clock and the local clock.

The limit may be rewritten at any moment, and the result is defined in both directions. A larger limit lets the count continue to the new value, and nothing happens as it passes the old one. A smaller limit makes the next frame return the count to zero without a capture or an interrupt. A limit of zero stops matching altogether.

A three-state controller governs the counting. `ST_IDLE` holds the count at zero while the limit is zero. `ST_COUNT` advances the count on each frame and signals a match when a frame brings the count to the limit. `ST_SHRINK` waits for the next frame after the limit has been lowered. The transitions are as follows. A nonzero write moves `ST_IDLE` to `ST_COUNT`. A write of zero moves `ST_COUNT` or `ST_SHRINK` to `ST_IDLE`. A nonzero write below the current limit moves `ST_COUNT` to `ST_SHRINK`. A frame moves `ST_SHRINK` back to `ST_COUNT` with the count cleared. In every other case the controller stays in its current state.

Top module: `frame_stamp_unit`

## Requirements
- R1: After reset the limit readback, the snapshot and the interrupt are all zero.
- R2: Limit readback returns the last written bits 15:0 in bits 15:0, and bits 31:16 always read as zero.
- R3: The snapshot takes the timer value of the exact clock cycle in which a frame strobe brings the count to the limit. The new snapshot value is readable from the next cycle, and the snapshot holds its value at all other times.
- R4: Every match sets the interrupt output, which stays high until it is cleared.
- R5: A clear pulse drops the interrupt one cycle later, unless a match occurs in the same cycle, in which case the interrupt stays high.
- R6: After a match the count restarts from zero, so with an unchanged limit N a match occurs on every Nth frame.
- R7: Raising the limit while counting produces no event when the count passes the old limit, and the next match occurs at the new limit.
- R8: Lowering the limit to a nonzero value makes the next frame reset the count to zero with no capture and no interrupt. Counting then resumes from zero.
- R9: While the limit is zero, frames produce no capture and no interrupt.
- R10: A frame in the same cycle as a limit write is judged against the limit that held before the write.
- R11: The timer increments by one every clock modulo 2^32, and captures never stop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| frame_i | input | 1 | Single-cycle frame strobe, synchronous to clk |
| thr_wr_en_i | input | 1 | Write strobe for the limit register |
| thr_wr_data_i | input | 32 | Write data. Only bits 15:0 are kept |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt |
| thr_rd_data_o | output | 32 | Limit register readback |
| snap_rd_data_o | output | 32 | Snapshot register readback |
| irq_o | output | 1 | Sticky interrupt level |

## Verification
The clear pulse and a match can occur in the same cycle. So can a frame strobe and a limit write. The stimulus table places a clear on the same cycle as a matching frame and checks that the interrupt stays high and that a fresh snapshot appears. It also places a lowering write on the same cycle as a frame that matches the old limit. That frame must still capture. The following frame must reset the count silently, even though under the new limit it would otherwise have matched.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SHRINK = 2'd2
    } fsu_state_e;
endpackage

// File: rtl/fsu_timer.sv
module fsu_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TMR_W-1:0] timer_o
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + ONE;
    end

    assign timer_o = tick_q;

    // R11: steps by one on every clock, wrapping naturally
    a_r11_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tick_q == $past(tick_q) + ONE);
endmodule

// File: rtl/fsu_ctrl.sv
module fsu_ctrl
    import fsu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] thr_o,
    output logic             match_o
);
    localparam logic [CNT_W:0] INC_ONE = (CNT_W+1)'(1);

    fsu_state_e       state_q, state_d;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] wr_val;
    logic [CNT_W:0]   cnt_inc;
    logic             wr_zero, wr_lower, hit;

    assign wr_val   = wr_data_i[CNT_W-1:0];
    assign wr_zero  = wr_en_i && (wr_val == '0);
    assign wr_lower = wr_en_i && (wr_val != '0) && (wr_val < thr_q);
    assign cnt_inc  = {1'b0, cnt_q} + INC_ONE;
    assign hit      = (cnt_inc == {1'b0, thr_q});

    // limit register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       thr_q <= '0;
        else if (wr_en_i) thr_q <= wr_val;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en_i && !wr_zero) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (wr_zero)       state_d = ST_IDLE;
                else if (wr_lower) state_d = ST_SHRINK;
            end
            ST_SHRINK: begin
                if (wr_zero)      state_d = ST_IDLE;
                else if (frame_i) state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and count datapath
    always_comb begin
        match_o = 1'b0;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: cnt_d = '0;
            ST_COUNT: begin
                if (frame_i) begin
                    if (hit) begin
                        match_o = 1'b1;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_SHRINK: begin
                if (frame_i) cnt_d = '0;
            end
            default: cnt_d = '0;
        endcase
        if (wr_zero) cnt_d = '0;
    end

    assign thr_o = thr_q;

    // R9: a zero limit never matches
    a_r9_zero_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q == '0) |-> !match_o);
    // R8: the frame after a lowering write is silent
    a_r8_shrink_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHRINK) |-> !match_o);
    // R7: while counting, the count stays below the limit
    a_r7_count_below: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q < thr_q));
    // R6: a match restarts the count from zero
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (cnt_q == '0));
endmodule

// File: rtl/fsu_capture.sv
module fsu_capture #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match_i,
    input  logic             clr_i,
    input  logic [TMR_W-1:0] timer_i,
    output logic [TMR_W-1:0] snap_o,
    output logic             irq_o
);
    logic [TMR_W-1:0] snap_q;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (match_i) snap_q <= timer_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (match_i) irq_q <= 1'b1;
        else if (clr_i)   irq_q <= 1'b0;
    end

    assign snap_o = snap_q;
    assign irq_o  = irq_q;

    // R4: a match raises the interrupt on the next cycle
    a_r4_irq_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> irq_o);
    // R4: the interrupt holds until cleared
    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);
    // R5: a clear with no match drops the interrupt
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !match_i) |=> !irq_o);
    // R3: the snapshot changes only on a match
    a_r3_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !match_i |=> $stable(snap_o));
endmodule

// File: rtl/frame_stamp_unit.sv
module frame_stamp_unit #(
    parameter int TMR_W = 32,
    parameter int CNT_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             thr_wr_en_i,
    input  logic [REG_W-1:0] thr_wr_data_i,
    input  logic             irq_clr_i,
    output logic [REG_W-1:0] thr_rd_data_o,
    output logic [TMR_W-1:0] snap_rd_data_o,
    output logic             irq_o
);
    localparam int RSV_W = REG_W - CNT_W;

    logic [TMR_W-1:0] timer;
    logic [CNT_W-1:0] thr;
    logic             match;
    logic             unused_rsv;

    assign unused_rsv = ^thr_wr_data_i[REG_W-1:CNT_W];

    fsu_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .timer_o (timer)
    );

    fsu_ctrl #(.CNT_W(CNT_W), .REG_W(REG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (frame_i),
        .wr_en_i   (thr_wr_en_i),
        .wr_data_i (thr_wr_data_i),
        .thr_o     (thr),
        .match_o   (match)
    );

    fsu_capture #(.TMR_W(TMR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .clr_i   (irq_clr_i),
        .timer_i (timer),
        .snap_o  (snap_rd_data_o),
        .irq_o   (irq_o)
    );

    generate
        if (RSV_W > 0) begin : g_pad
            assign thr_rd_data_o = {{RSV_W{1'b0}}, thr};
        end else begin : g_nopad
            assign thr_rd_data_o = thr;
        end
    endgenerate

    // R2: the reserved upper bits never read as one
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        thr_rd_data_o[REG_W-1:CNT_W] == '0);
endmodule

// File: tb/frame_stamp_unit_tb.sv
`timescale 1ns/1ps
module frame_stamp_unit_tb;
    typedef struct packed {
        logic        wr;
        logic [15:0] wd;
        logic        frm;
        logic        clr;
        logic        eirq;
        logic        ecap;
    } vec_t;

    localparam int NV = 44;
    // fields: wr, wd, frm, clr, expected irq, expected capture
    localparam vec_t VT [NV] = '{
        '{1'b1, 16'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // 0 limit 3
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 1 count 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 2 count 2
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // 3 idle gap
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 4 R3 R4 match
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // 5 R6 restart, count 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // 6 count 2
        '{1'b0, 16'd0, 1'b1, 1'b1, 1'b1, 1'b1}, // 7 R5 clear and match together
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // 8 R5 clear
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // 9
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 10 count 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 11 count 2
        '{1'b1, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0}, // 12 R7 raise to 5
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 13 R7 passes old 3
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 14 count 4
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 15 R7 match at 5
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // 16 clear
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 17 count 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 18 count 2
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 19 count 3
        '{1'b1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // 20 R8 lower to 2
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 21 R8 silent reset
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 22 count 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 23 R8 match at 2
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // 24 clear
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 25 count 1
        '{1'b1, 16'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // 26 R8 lower to 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 27 R8 silent reset
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 28 R6 match every frame
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 29 R6 back-to-back match
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // 30 clear
        '{1'b1, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // 31 R9 limit zero
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 32 R9 no event
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 33 R9 no event
        '{1'b1, 16'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // 34 limit 2
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 35 count 1
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 36 match
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // 37 clear
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // 38 count 1
        '{1'b1, 16'd1, 1'b1, 1'b0, 1'b1, 1'b1}, // 39 R10 frame with lowering write
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // 40 R10 R8 silent reset
        '{1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // 41 clear
        '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // 42 match at 1
        '{1'b0, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0}  // 43 R4 sticky
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_i = 1'b0;
    logic        thr_wr_en_i = 1'b0;
    logic [31:0] thr_wr_data_i = '0;
    logic        irq_clr_i = 1'b0;
    logic [31:0] thr_rd_data_o;
    logic [31:0] snap_rd_data_o;
    logic        irq_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] tb_cyc = '0;
    logic [31:0] exp_snap = '0;
    logic [15:0] exp_thr = '0;
    logic [31:0] cand;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= '0;
        else        tb_cyc <= tb_cyc + 32'd1;
    end

    frame_stamp_unit u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_i        (frame_i),
        .thr_wr_en_i    (thr_wr_en_i),
        .thr_wr_data_i  (thr_wr_data_i),
        .irq_clr_i      (irq_clr_i),
        .thr_rd_data_o  (thr_rd_data_o),
        .snap_rd_data_o (snap_rd_data_o),
        .irq_o          (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 limit", thr_rd_data_o, 32'h0);
        check("R1 snapshot", snap_rd_data_o, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            thr_wr_en_i   = VT[i].wr;
            thr_wr_data_i = {16'hFFFF, VT[i].wd};
            frame_i       = VT[i].frm;
            irq_clr_i     = VT[i].clr;
            cand          = tb_cyc;
            if (VT[i].wr) exp_thr = VT[i].wd;
            @(negedge clk);
            thr_wr_en_i = 1'b0;
            frame_i     = 1'b0;
            irq_clr_i   = 1'b0;
            if (VT[i].ecap) exp_snap = cand;
            check("R4 R5 irq", {31'h0, irq_o}, {31'h0, VT[i].eirq});
            check("R3 R11 snapshot", snap_rd_data_o, exp_snap);
            check("R2 limit", thr_rd_data_o, {16'h0, exp_thr});
        end

        // R2: upper write bits discarded
        thr_wr_en_i   = 1'b1;
        thr_wr_data_i = 32'hABCD_1234;
        @(negedge clk);
        thr_wr_en_i = 1'b0;
        check("R2 reserved bits", thr_rd_data_o, 32'h0000_1234);
        check("R4 irq still held", {31'h0, irq_o}, 32'h1);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 limit after reset", thr_rd_data_o, 32'h0);
        check("R1 snapshot after reset", snap_rd_data_o, 32'h0);
        check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule